// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block answers three-wire serial memory commands on a chip-select (`cs`), a serial clock (`sk`) and a serial data input (`di`). It returns read data on `dout`, and `dout_oe` marks when a driver should enable the pad, so high impedance is modelled by that separate enable. Data lives in an internal array of 256 words of 16 bits.

All logic runs on the system clock `clk`. The block detects rising edges of `sk` by comparing the input with a registered copy. A frame opens at the first 1 seen on `di` at a rising `sk` edge while `cs` is high. A 2-bit opcode and an 8-bit address follow, MSB first. A read streams words for as long as `sk` keeps toggling and wraps at the top of the array. Writes are gated by an enable latch that is cleared at reset and is changed only by two extended commands.

The controller has six states:
- `ST_IDLE` waits for the start bit and goes to `ST_OPCODE` when `di`=1.
- `ST_OPCODE` collects two bits and goes to `ST_ADDR`.
- `ST_ADDR` collects eight bits. It then goes to `ST_READ` for opcode 10, to `ST_WRITE` for opcode 01, and otherwise to `ST_HOLD`.
- `ST_READ` stays there and streams data.
- `ST_WRITE` collects 16 bits and then goes to `ST_HOLD`.
- `ST_HOLD` ignores everything until `cs` falls.

From any state, `cs` low returns the controller to `ST_IDLE`.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset `dout_oe` is 0 and the write-enable latch is clear, so a WRITE sent before any enable command leaves the array unchanged (all words reset to 0).
- R2: While `cs` is high, 0 bits on `di` before the start bit are ignored, and the frame starts at the first 1.
- R3: After a READ frame (start 1, opcode 10, 8 address bits MSB first), `dout_oe` rises on the `sk` rise that samples the last address bit, and `dout` is then a dummy 0.
- R4: Each later `sk` rise puts the next data bit on `dout`, MSB first. While `cs` is high, `dout` changes only on `sk` rises.
- R5: If `sk` keeps toggling after bit 0 of a word, the next address's word follows at once with no dummy bit.
- R6: Sequential reading goes on from address 255 to address 0.
- R7: A WRITE (opcode 01, address, then 16 data bits MSB first) stores its data only while the latch is set.
- R8: With opcode 00, address bits [7:6] = 11 set the latch and 00 clear it. Any other value leaves the latch unchanged. The latch changes only on an `sk` rise with `cs` high.
- R9: READ returns stored data whatever the state of the latch.
- R10: `cs` low drops `dout_oe` one clock later and aborts the frame. A WRITE with fewer than 16 data bits stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on `clk` |
| di | input | 1 | Serial command and data input |
| dout | output | 1 | Serial read data |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |

## Verification
Every serial result registers one `clk` after the `clk` edge that first sees `sk` high. The bench therefore raises `sk` on a falling `clk` edge and reads `dout`/`dout_oe` on the next falling edge, before it lowers `sk`. This applies to the dummy 0 that comes with the last address bit and to every data bit after it. A committed write reaches the array one `clk` after its 16th data bit, and a dropped `cs` clears `dout_oe` one `clk` later. The bench waits at least two `clk` cycles after closing a frame before it starts a read-back or samples the enable.

// File: rtl/mw_slave_pkg.sv
package mw_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_READ   = 3'd3,
        ST_WRITE  = 3'd4,
        ST_HOLD   = 3'd5
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_OTHER = 2'b11
    } mw_op_e;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);

    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign sk_rise = sk & ~sk_q;

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_slave_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam int MAX_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAX_W) + 1;
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    mw_state_e          state_q, state_nx;
    logic               sk_rise;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  addr_nx;
    logic [ADDR_W-1:0]  rd_addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [DATA_W-1:0]  rd_word;
    logic [BIT_W-1:0]   bit_idx;
    logic               wen_q;
    logic               wr_en_q;

    mw_sk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .sk_rise (sk_rise)
    );

    mw_word_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_q),
        .wr_addr (addr_q),
        .wr_data (data_q),
        .rd_addr (rd_addr_q),
        .rd_data (rd_word)
    );

    assign addr_nx = {addr_q[ADDR_W-2:0], di};
    assign bit_idx = BIT_W'(DATA_W - 1) - cnt_q[BIT_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state_q;
        if (!cs) begin
            state_nx = ST_IDLE;
        end else if (sk_rise) begin
            unique case (state_q)
                ST_IDLE:   if (di) state_nx = ST_OPCODE;
                ST_OPCODE: if (cnt_q == OP_LAST) state_nx = ST_ADDR;
                ST_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        if (op_q == OP_READ)       state_nx = ST_READ;
                        else if (op_q == OP_WRITE) state_nx = ST_WRITE;
                        else                       state_nx = ST_HOLD;
                    end
                end
                ST_READ:   state_nx = ST_READ;
                ST_WRITE:  if (cnt_q == DATA_LAST) state_nx = ST_HOLD;
                ST_HOLD:   state_nx = ST_HOLD;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            op_q      <= '0;
            addr_q    <= '0;
            rd_addr_q <= '0;
            data_q    <= '0;
            wen_q     <= 1'b0;
            wr_en_q   <= 1'b0;
            dout      <= 1'b0;
            dout_oe   <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (!cs) begin
                cnt_q   <= '0;
                dout    <= 1'b0;
                dout_oe <= 1'b0;
            end else if (sk_rise) begin
                unique case (state_q)
                    ST_IDLE: cnt_q <= '0;
                    ST_OPCODE: begin
                        op_q  <= {op_q[0], di};
                        cnt_q <= (cnt_q == OP_LAST) ? '0 : cnt_q + CNT_W'(1);
                    end
                    ST_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q <= '0;
                            if (op_q == OP_READ) begin
                                rd_addr_q <= addr_nx;
                                dout      <= 1'b0;
                                dout_oe   <= 1'b1;
                            end else if (op_q == OP_EXT) begin
                                if (addr_nx[ADDR_W-1 -: 2] == EXT_ENABLE)
                                    wen_q <= 1'b1;
                                else if (addr_nx[ADDR_W-1 -: 2] == EXT_DISABLE)
                                    wen_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_READ: begin
                        dout <= rd_word[bit_idx];
                        if (cnt_q == DATA_LAST) begin
                            cnt_q     <= '0;
                            rd_addr_q <= rd_addr_q + ADDR_W'(1);
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_WRITE: begin
                        data_q <= {data_q[DATA_W-2:0], di};
                        if (cnt_q == DATA_LAST) begin
                            cnt_q   <= '0;
                            wr_en_q <= wen_q;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_HOLD: cnt_q <= '0;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sk,
    input logic dout,
    input logic dout_oe,
    input logic wen
);

    logic sk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= sk;
    end

    // R10
    cs_drop_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_oe);

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !(sk && !sk_d)) |=> $stable(dout));

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> (dout == 1'b0));

    // R3
    oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && sk && !sk_d) |=> !$rose(dout_oe));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && sk && !sk_d) |=> $stable(wen));

endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .dout    (dout),
    .dout_oe (dout_oe),
    .wen     (wen_q)
);

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout;
    logic dout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic last_o, last_oe;

    always #2.5 clk = ~clk;

    mw_eeprom_slave u_mw_eeprom_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // {address, data}
    localparam logic [23:0] VEC [6] = '{
        {8'h01, 16'hA5C3},
        {8'h02, 16'h0001},
        {8'h7F, 16'h8000},
        {8'h80, 16'hFFFF},
        {8'hFE, 16'h5A5A},
        {8'h55, 16'h3C96}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        @(negedge clk);
        di = b;
        sk = 1'b1;
        @(negedge clk);
        last_o  = dout;
        last_oe = dout_oe;
        sk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] addr);
        cs = 1'b1;
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = 7; i >= 0; i--) sk_bit(addr[i]);
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs = 1'b0;
        sk = 1'b0;
        di = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_ext(input logic [7:0] addr);
        send_cmd(2'b00, addr);
        end_frame();
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [15:0] data);
        send_cmd(2'b01, addr);
        for (int i = 15; i >= 0; i--) sk_bit(data[i]);
        end_frame();
    endtask

    task automatic read_word(output logic [15:0] w);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            sk_bit(1'b0);
            w = {w[14:0], last_o};
        end
    endtask

    task automatic read_one(input logic [7:0] addr, output logic [15:0] w);
        send_cmd(2'b10, addr);
        chk("R3 oe after address", {31'd0, last_oe}, 32'd1);
        chk("R3 dummy zero", {31'd0, last_o}, 32'd0);
        read_word(w);
        end_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and disabled latch
        chk("R1 oe at reset", {31'd0, dout_oe}, 32'd0);
        do_write(8'h10, 16'hBEEF);
        read_one(8'h10, w);
        chk("R1 write before enable ignored", {16'd0, w}, 32'd0);

        // table walk: R7 write, R4 read MSB first
        do_ext(8'hC0);
        for (int i = 0; i < 6; i++) do_write(VEC[i][23:16], VEC[i][15:0]);
        for (int i = 0; i < 6; i++) begin
            read_one(VEC[i][23:16], w);
            chk("R4 R7 table read", {16'd0, w}, {16'd0, VEC[i][15:0]});
        end

        // R2: leading zeros before start bit
        cs = 1'b1;
        sk_bit(1'b0);
        sk_bit(1'b0);
        sk_bit(1'b0);
        chk("R2 idle zeros keep oe low", {31'd0, last_oe}, 32'd0);
        send_cmd(2'b10, 8'h55);
        chk("R2 dummy after late start", {30'd0, last_oe, last_o}, 32'd2);
        read_word(w);
        chk("R2 data after late start", {16'd0, w}, 32'h3C96);
        end_frame();

        // R5: sequential read 0x01 -> 0x02, no dummy between
        send_cmd(2'b10, 8'h01);
        read_word(w);
        chk("R5 first word", {16'd0, w}, 32'hA5C3);
        read_word(w);
        chk("R5 next word no gap", {16'd0, w}, 32'h0001);
        end_frame();

        // R6: wrap 0xFF -> 0x00
        do_write(8'hFF, 16'hABCD);
        do_write(8'h00, 16'h1234);
        send_cmd(2'b10, 8'hFE);
        read_word(w);
        chk("R6 word FE", {16'd0, w}, 32'h5A5A);
        read_word(w);
        chk("R6 word FF", {16'd0, w}, 32'hABCD);
        read_word(w);
        chk("R6 wrap to 00", {16'd0, w}, 32'h1234);
        end_frame();

        // R8: enabled latch, non-matching extended code keeps it set
        do_ext(8'h80);
        do_write(8'h40, 16'h7777);
        read_one(8'h40, w);
        chk("R8 ext 10 keeps latch set", {16'd0, w}, 32'h7777);

        // R8: disable blocks writes
        do_ext(8'h00);
        do_write(8'h40, 16'h1111);
        read_one(8'h40, w);
        chk("R8 disable blocks write", {16'd0, w}, 32'h7777);

        // R8: non-matching code keeps it clear
        do_ext(8'h40);
        do_write(8'h41, 16'h2222);
        read_one(8'h41, w);
        chk("R8 ext 01 keeps latch clear", {16'd0, w}, 32'd0);

        // R9: read with latch clear
        read_one(8'h80, w);
        chk("R9 read while disabled", {16'd0, w}, 32'hFFFF);

        // R10: partial write not stored
        do_ext(8'hC0);
        send_cmd(2'b01, 8'h30);
        for (int i = 0; i < 10; i++) sk_bit(1'b1);
        end_frame();
        read_one(8'h30, w);
        chk("R10 partial write dropped", {16'd0, w}, 32'd0);

        // R10: cs drop mid-read tri-states
        send_cmd(2'b10, 8'h7F);
        for (int i = 0; i < 5; i++) sk_bit(1'b0);
        chk("R10 oe during read", {31'd0, last_oe}, 32'd1);
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
        chk("R10 oe after cs low", {31'd0, dout_oe}, 32'd0);
        @(negedge clk);

        // R10: frame aborted, new frame decodes cleanly
        read_one(8'h7F, w);
        chk("R10 clean frame after abort", {16'd0, w}, 32'h8000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule